// File: doc/BRIEF.md
# Character Box Resampler to a 16x16 Grid

This block takes one character whose bounding box may have any height and width from 1 to 255 pixels and resamples it onto a fixed 16 by 16 grid of 8-bit gray pixels. This gives later matching stages a character of constant size. The character sits in an external source buffer. The block reads that buffer through a random-access port that returns data one cycle after the request. For every grid pixel it fetches four neighbouring source pixels. It weights them bilinearly from the fractional part of the mapped position and writes one output pixel. A full run makes 1024 source reads and 256 output writes, then pulses a completion flag.

An output pixel at grid row r and column c maps to the source position r*H/16, c*W/16. Each position is kept as an integer part and an 8-bit fraction, so one step along an axis is the box size divided by 16 in 8.8 fixed point. The neighbour one row below or one column to the right can fall past the last row or column of the box. How it is treated then depends on `edge_zero`: it either takes the edge pixel or counts as background zero. The read address is always held inside the box.

The control is a six-state machine:

- **IDLE**: waits for `start`, then latches the box and the edge mode and moves to **PREP**.
- **PREP**: clears the accumulator and moves to **FETCH**.
- **FETCH**: issues one read per cycle for taps 0 to 3. After tap 3 it moves to **DRAIN**.
- **DRAIN**: absorbs the last read and moves to **EMIT**.
- **EMIT**: writes the pixel. It returns to **PREP**, or goes to **FINISH** after pixel 255.
- **FINISH**: pulses `done` and moves back to **IDLE**.

Top module: `bbox_warp16`

## Requirements
- R1: While reset is held and after it is released with no `start`, `src_re`, `out_we` and `done` stay low.
- R2: Output pixel (r,c) uses a source row base of floor(r*H/16) with fraction fy = (16*r*H) mod 256. It uses a column base of floor(c*W/16) with fraction fx = (16*c*W) mod 256.
- R3: The taps are read in the order (y0,x0), (y0,x1), (y1,x0), (y1,x1), with y1 = y0+1 and x1 = x0+1. Their weights are (256-fx)(256-fy), fx(256-fy), (256-fx)fy and fx*fy. The pixel is (weighted sum + 32768) >> 16, saturated to 255.
- R4: Each output pixel takes exactly four source reads, so one run makes 1024 reads.
- R5: Output pixels are written in raster order, with `out_addr` = 16*row + col running from 0 to 255, for exactly 256 writes.
- R6: `done` is high for exactly one cycle, in the cycle after the write to address 255.
- R7: With `edge_zero` = 0, a neighbour past the last row or column takes the pixel on that edge. `src_row` < H and `src_col` < W hold for every read.
- R8: With `edge_zero` = 1, a neighbour past the last row or column contributes zero. Its read is still issued, at the clamped address.
- R9: A 16x16 box is copied unchanged, pixel for pixel.
- R10: A `start` that arrives while a run is in progress is ignored. The run completes on the box and mode latched at its own start.
- R11: A box dimension of 0 is treated as 1.
- R12: `src_data` is taken in the cycle after the one in which `src_re` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| box_h | input | 8 | Box height in source rows |
| box_w | input | 8 | Box width in source columns |
| edge_zero | input | 1 | 1: neighbours past the box are zero; 0: edge pixel repeats |
| src_re | output | 1 | Source read request |
| src_row | output | 8 | Source read row |
| src_col | output | 8 | Source read column |
| src_data | input | 8 | Source pixel, valid the cycle after the request |
| out_we | output | 1 | Output pixel write strobe |
| out_addr | output | 8 | Grid address, 16*row + col |
| out_data | output | 8 | Resampled pixel |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench drives a tall, non-square 56x42 box, a full 255x255 box, a 16x16 box and 1x1 boxes. On a 1-pixel box, every grid neighbour falls past the edge. A design that swapped the row and column steps, or mis-assigned the tap weights, would give wrong pixels on the non-square box. A design that took `src_data` in the wrong cycle would pick up the filler value the source model drives between reads. A design that ignored the edge mode would give flat 255 in zero mode on the 1x1 box instead of a ramp that falls toward the far corner. A design that let the address run past the box would be caught by the read bounds count. The bench also starts a run with a zero height, and sends a second `start` mid-run with a different box. A design that failed to latch the box, or took 0 literally, would write wrong pixels or raise `done` twice.

// File: rtl/warp16_pkg.sv
package warp16_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_FETCH,
        ST_DRAIN,
        ST_EMIT,
        ST_FINISH
    } warp_state_e;

endpackage

// File: rtl/warp_axis.sv
// Maps one grid index onto one source axis: integer base, clamped
// next neighbour, 8-bit fraction and a flag for a neighbour past the edge.
module warp_axis #(
    parameter int COORD_W   = 8,
    parameter int GRID_LOG2 = 4,
    parameter int FRAC_W    = 8
) (
    input  logic [GRID_LOG2-1:0] idx,
    input  logic [COORD_W-1:0]   dim,
    output logic [COORD_W-1:0]   base,
    output logic [COORD_W-1:0]   nxt,
    output logic [FRAC_W-1:0]    frac,
    output logic                 past_edge
);
    localparam int PROD_W = GRID_LOG2 + COORD_W;
    localparam int PAD_W  = FRAC_W - GRID_LOG2;
    localparam int POS_W  = PROD_W + PAD_W;

    logic [PROD_W-1:0] prod;
    logic [POS_W-1:0]  pos;
    logic [COORD_W:0]  nxt_raw;

    always_comb begin
        prod      = PROD_W'(idx) * PROD_W'(dim);
        pos       = {prod, {PAD_W{1'b0}}};
        base      = pos[POS_W-1 -: COORD_W];
        frac      = pos[FRAC_W-1:0];
        nxt_raw   = {1'b0, base} + 1'b1;
        past_edge = (nxt_raw >= {1'b0, dim});
        nxt       = past_edge ? (dim - 1'b1) : nxt_raw[COORD_W-1:0];
    end

    always_comb begin
        if (dim != '0) begin
            AST_BASE_IN_BOX: assert (base < dim); // R2
        end
    end

endmodule

// File: rtl/warp_mac.sv
// Weighted four-tap accumulator with round-half-up and saturation.
module warp_mac #(
    parameter int PIX_W  = 8,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              en,
    input  logic [1:0]        tap,
    input  logic [FRAC_W-1:0] fx,
    input  logic [FRAC_W-1:0] fy,
    input  logic              zero_x,
    input  logic              zero_y,
    input  logic [PIX_W-1:0]  pix,
    output logic [PIX_W-1:0]  result
);
    localparam int WGT_W  = FRAC_W + 1;
    localparam int PROD_W = 2 * WGT_W;
    localparam int TERM_W = PROD_W + PIX_W;
    localparam int ACC_W  = TERM_W + 2;
    localparam int RND_SH = 2 * FRAC_W;
    localparam logic [WGT_W-1:0] ONE     = WGT_W'(1 << FRAC_W);
    localparam logic [ACC_W-1:0] HALF    = ACC_W'(1) << (RND_SH - 1);
    localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

    logic [WGT_W-1:0]  wx, wy;
    logic [PROD_W-1:0] wgt;
    logic [TERM_W-1:0] term;
    logic              kill;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  rnd, shifted;

    always_comb begin
        wx   = tap[0] ? {1'b0, fx} : (ONE - {1'b0, fx});
        wy   = tap[1] ? {1'b0, fy} : (ONE - {1'b0, fy});
        wgt  = PROD_W'(wx) * PROD_W'(wy);
        kill = (tap[0] & zero_x) | (tap[1] & zero_y);
        term = kill ? '0 : TERM_W'(wgt) * TERM_W'(pix);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (clear)  acc_q <= '0;
        else if (en)     acc_q <= acc_q + ACC_W'(term);
    end

    always_comb begin
        rnd     = acc_q + HALF;
        shifted = rnd >> RND_SH;
        result  = (shifted > ACC_W'(PIX_MAX)) ? PIX_MAX : shifted[PIX_W-1:0];
    end

    AST_ACC_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clear) |=> (acc_q >= $past(acc_q))); // R3

endmodule

// File: rtl/warp_ctrl.sv
// Sequencer: latches the job, walks 256 grid pixels, four taps each.
module warp_ctrl
    import warp16_pkg::*;
#(
    parameter int COORD_W   = 8,
    parameter int GRID_LOG2 = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [COORD_W-1:0]       box_h,
    input  logic [COORD_W-1:0]       box_w,
    input  logic                     edge_zero,
    output logic [COORD_W-1:0]       h_q,
    output logic [COORD_W-1:0]       w_q,
    output logic                     zero_q,
    output logic [2*GRID_LOG2-1:0]   px_idx,
    output logic [1:0]               tap,
    output logic [1:0]               acc_tap,
    output logic                     src_re,
    output logic                     acc_clr,
    output logic                     acc_en,
    output logic                     out_we,
    output logic                     done
);
    localparam int NPIX_W = 2 * GRID_LOG2;
    localparam logic [NPIX_W-1:0] LAST_PX  = '1;
    localparam logic [1:0]        LAST_TAP = 2'd3;

    warp_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_PREP;
            ST_PREP:   state_d = ST_FETCH;
            ST_FETCH:  if (tap == LAST_TAP) state_d = ST_DRAIN;
            ST_DRAIN:  state_d = ST_EMIT;
            ST_EMIT:   state_d = (px_idx == LAST_PX) ? ST_FINISH : ST_PREP;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        src_re  = 1'b0;
        acc_clr = 1'b0;
        out_we  = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_PREP:   acc_clr = 1'b1;
            ST_FETCH:  src_re  = 1'b1;
            ST_DRAIN:  ;
            ST_EMIT:   out_we  = 1'b1;
            ST_FINISH: done    = 1'b1;
            default:   ;
        endcase
    end

    // job latch and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q     <= COORD_W'(1);
            w_q     <= COORD_W'(1);
            zero_q  <= 1'b0;
            px_idx  <= '0;
            tap     <= '0;
            acc_tap <= '0;
            acc_en  <= 1'b0;
        end else begin
            acc_en  <= src_re;
            acc_tap <= tap;
            if (state_q == ST_IDLE && start) begin
                h_q    <= (box_h == '0) ? COORD_W'(1) : box_h;
                w_q    <= (box_w == '0) ? COORD_W'(1) : box_w;
                zero_q <= edge_zero;
                px_idx <= '0;
            end
            if (state_q == ST_PREP)  tap <= '0;
            if (state_q == ST_FETCH) tap <= tap + 1'b1;
            if (state_q == ST_EMIT)  px_idx <= px_idx + 1'b1;
        end
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(out_we) && $past(px_idx) == LAST_PX)); // R6

    AST_DIMS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(h_q) && $stable(w_q) && $stable(zero_q))); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

endmodule

// File: rtl/bbox_warp16.sv
module bbox_warp16 #(
    parameter int PIX_W     = 8,
    parameter int COORD_W   = 8,
    parameter int GRID_LOG2 = 4,
    parameter int FRAC_W    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [COORD_W-1:0]     box_h,
    input  logic [COORD_W-1:0]     box_w,
    input  logic                   edge_zero,
    output logic                   src_re,
    output logic [COORD_W-1:0]     src_row,
    output logic [COORD_W-1:0]     src_col,
    input  logic [PIX_W-1:0]       src_data,
    output logic                   out_we,
    output logic [2*GRID_LOG2-1:0] out_addr,
    output logic [PIX_W-1:0]       out_data,
    output logic                   done
);
    localparam int NPIX_W = 2 * GRID_LOG2;
    localparam int NAXIS  = 2;   // 0: rows (y), 1: columns (x)

    logic [COORD_W-1:0] h_q, w_q;
    logic               zero_q;
    logic [NPIX_W-1:0]  px_idx;
    logic [1:0]         tap, acc_tap;
    logic               acc_clr, acc_en;

    logic [GRID_LOG2-1:0] ax_idx  [NAXIS];
    logic [COORD_W-1:0]   ax_dim  [NAXIS];
    logic [COORD_W-1:0]   ax_base [NAXIS];
    logic [COORD_W-1:0]   ax_nxt  [NAXIS];
    logic [FRAC_W-1:0]    ax_frac [NAXIS];
    logic                 ax_past [NAXIS];

    warp_ctrl #(
        .COORD_W   (COORD_W),
        .GRID_LOG2 (GRID_LOG2)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .box_h     (box_h),
        .box_w     (box_w),
        .edge_zero (edge_zero),
        .h_q       (h_q),
        .w_q       (w_q),
        .zero_q    (zero_q),
        .px_idx    (px_idx),
        .tap       (tap),
        .acc_tap   (acc_tap),
        .src_re    (src_re),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en),
        .out_we    (out_we),
        .done      (done)
    );

    assign ax_idx[0] = px_idx[NPIX_W-1 -: GRID_LOG2];
    assign ax_idx[1] = px_idx[GRID_LOG2-1:0];
    assign ax_dim[0] = h_q;
    assign ax_dim[1] = w_q;

    for (genvar a = 0; a < NAXIS; a++) begin : g_axis
        warp_axis #(
            .COORD_W   (COORD_W),
            .GRID_LOG2 (GRID_LOG2),
            .FRAC_W    (FRAC_W)
        ) u_axis (
            .idx       (ax_idx[a]),
            .dim       (ax_dim[a]),
            .base      (ax_base[a]),
            .nxt       (ax_nxt[a]),
            .frac      (ax_frac[a]),
            .past_edge (ax_past[a])
        );
    end

    // tap bit 1 selects the lower row, bit 0 the right column
    assign src_row  = tap[1] ? ax_nxt[0] : ax_base[0];
    assign src_col  = tap[0] ? ax_nxt[1] : ax_base[1];
    assign out_addr = px_idx;

    warp_mac #(
        .PIX_W  (PIX_W),
        .FRAC_W (FRAC_W)
    ) u_mac (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (acc_clr),
        .en     (acc_en),
        .tap    (acc_tap),
        .fx     (ax_frac[1]),
        .fy     (ax_frac[0]),
        .zero_x (zero_q & ax_past[1]),
        .zero_y (zero_q & ax_past[0]),
        .pix    (src_data),
        .result (out_data)
    );

    // checking state
    logic [2:0]        rd_in_px;
    logic [NPIX_W-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_in_px  <= '0;
            last_addr <= '0;
        end else begin
            if (acc_clr)     rd_in_px <= '0;
            else if (src_re) rd_in_px <= rd_in_px + 1'b1;
            if (out_we)      last_addr <= out_addr;
        end
    end

    AST_FOUR_READS_PER_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        out_we |-> (rd_in_px == 3'd4)); // R4

    AST_READ_IN_BOX: assert property (@(posedge clk) disable iff (!rst_n)
        src_re |-> ((src_row < h_q) && (src_col < w_q))); // R7

    AST_RASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && out_addr != '0) |-> (out_addr == NPIX_W'(last_addr + 1'b1))); // R5

    AST_NO_WRITE_WHILE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_we && src_re)); // R4

endmodule

// File: tb/bbox_warp16_tb.sv
module bbox_warp16_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] box_h = '0, box_w = '0;
    logic       edge_zero = 1'b0;
    logic       src_re;
    logic [7:0] src_row, src_col;
    logic [7:0] src_data = 8'hA5;
    logic       out_we;
    logic [7:0] out_addr, out_data;
    logic       done;

    always #4 clk = ~clk;   // 125 MHz

    bbox_warp16 u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .box_h(box_h), .box_w(box_w),
        .edge_zero(edge_zero), .src_re(src_re), .src_row(src_row), .src_col(src_col),
        .src_data(src_data), .out_we(out_we), .out_addr(out_addr), .out_data(out_data),
        .done(done)
    );

    int checks = 0, errors = 0;
    int img_sel = 0, eff_h = 1, eff_w = 1;
    int rd_cnt, wr_cnt, done_cnt, order_bad, oob_cnt, done_early;
    int got [256];
    bit finished = 0;

    function automatic int pix(int img, int r, int c);
        case (img)
            0:       return (r * 7 + c * 13 + r * c) & 255;
            1:       return 255;
            2:       return ((r + c) & 1) ? 240 : 15;
            default: return 0;
        endcase
    endfunction

    function automatic int ref_pix(int h, int w, int z, int img, int idx);
        int r = idx / 16, c = idx % 16;
        int yp = r * h * 16, xp = c * w * 16;
        int y0 = yp / 256, fy = yp % 256, x0 = xp / 256, fx = xp % 256;
        int y1 = y0 + 1, x1 = x0 + 1;
        bit ye = (y1 >= h), xe = (x1 >= w);
        int p00, p01, p10, p11, s, v;
        if (ye) y1 = h - 1;
        if (xe) x1 = w - 1;
        p00 = pix(img, y0, x0);
        p01 = (z != 0 && xe) ? 0 : pix(img, y0, x1);
        p10 = (z != 0 && ye) ? 0 : pix(img, y1, x0);
        p11 = (z != 0 && (xe || ye)) ? 0 : pix(img, y1, x1);
        s = (256 - fx) * (256 - fy) * p00 + fx * (256 - fy) * p01
          + (256 - fx) * fy * p10 + fx * fy * p11;
        v = (s + 32768) >>> 16;
        return (v > 255) ? 255 : v;
    endfunction

    // synchronous source buffer: data one cycle after the request (R12)
    always @(posedge clk) begin
        if (src_re) src_data <= 8'(pix(img_sel, int'(src_row), int'(src_col)));
        else        src_data <= 8'hA5;
    end

    always @(negedge clk) begin
        if (src_re) begin
            rd_cnt++;
            if (int'(src_row) >= eff_h || int'(src_col) >= eff_w) oob_cnt++;
        end
        if (out_we) begin
            if (int'(out_addr) != (wr_cnt % 256)) order_bad++;
            got[out_addr] = int'(out_data);
            wr_cnt++;
        end
        if (done) begin
            done_cnt++;
            if (wr_cnt != 256) done_early++;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic clear_mon();
        rd_cnt = 0; wr_cnt = 0; done_cnt = 0; order_bad = 0; oob_cnt = 0; done_early = 0;
        for (int i = 0; i < 256; i++) got[i] = -1;
    endtask

    task automatic launch(int h, int w, int z, int img);
        @(negedge clk);
        box_h = 8'(h); box_w = 8'(w); edge_zero = (z != 0); img_sel = img;
        eff_h = (h == 0) ? 1 : h; eff_w = (w == 0) ? 1 : w;
        clear_mon();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_pixels(string req, int h, int w, int z, int img);
        int bad = 0, first = -1;
        for (int i = 0; i < 256; i++)
            if (got[i] != ref_pix(h, w, z, img, i)) begin
                bad++;
                if (first < 0) first = i;
            end
        checks++;
        if (bad != 0) begin
            errors++;
            $display("FAIL %s pixel %0d actual=%0d expected=%0d (%0d mismatches)",
                     req, first, got[first], ref_pix(h, w, z, img, first), bad);
        end
    endtask

    task automatic check_run_shape(string req);
        check(req, "reads", rd_cnt, 1024);         // R4
        check(req, "writes", wr_cnt, 256);         // R5
        check(req, "raster order errors", order_bad, 0);
        check(req, "out-of-box reads", oob_cnt, 0); // R7
        check(req, "done pulses", done_cnt, 1);    // R6
        check(req, "done before last write", done_early, 0);
    endtask

    task automatic t_reset();   // R1
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 3) rst_n = 1'b1;
            check("R1", "src_re", int'(src_re), 0);
            check("R1", "out_we", int'(out_we), 0);
            check("R1", "done", int'(done), 0);
        end
    endtask

    task automatic t_tall_box();   // R2 R3 R12 on a non-square box
        launch(56, 42, 0, 0);
        wait_done();
        check_pixels("R2/R3/R12 56x42", 56, 42, 0, 0);
        check_run_shape("R4/R5/R6 56x42");
    endtask

    task automatic t_identity();   // R9
        int bad = 0;
        launch(16, 16, 0, 0);
        wait_done();
        for (int i = 0; i < 256; i++)
            if (got[i] != pix(0, i / 16, i % 16)) bad++;
        check("R9", "identity mismatches", bad, 0);
    endtask

    task automatic t_single_clamp();   // R7 and R3 saturation bound
        int bad = 0;
        launch(1, 1, 0, 1);
        wait_done();
        for (int i = 0; i < 256; i++) if (got[i] != 255) bad++;
        check("R7", "1x1 edge-repeat pixels not 255", bad, 0);
        check_run_shape("R7 1x1");
    endtask

    task automatic t_single_zero();   // R8
        launch(1, 1, 1, 1);
        wait_done();
        check_pixels("R8 1x1 zero", 1, 1, 1, 1);
        check("R8", "corner pixel 255", got[255], ref_pix(1, 1, 1, 1, 255));
    endtask

    task automatic t_small_both();   // R7 R8 on a small checker box
        launch(5, 9, 1, 2);
        wait_done();
        check_pixels("R8 5x9 zero", 5, 9, 1, 2);
        launch(5, 9, 0, 2);
        wait_done();
        check_pixels("R7 5x9 clamp", 5, 9, 0, 2);
    endtask

    task automatic t_large();   // R2 at the top of the range
        launch(255, 255, 0, 0);
        wait_done();
        check_pixels("R2 255x255", 255, 255, 0, 0);
        check_run_shape("R4 255x255");
    endtask

    task automatic t_busy_start();   // R10
        launch(20, 30, 0, 0);
        repeat (100) @(negedge clk);
        box_h = 8'd5; box_w = 8'd5; edge_zero = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_pixels("R10 mid-run start", 20, 30, 0, 0);
        check("R10", "done pulses", done_cnt, 1);
        check("R10", "reads", rd_cnt, 1024);
    endtask

    task automatic t_zero_dim();   // R11
        launch(0, 7, 0, 0);
        wait_done();
        check_pixels("R11 height 0", 1, 7, 0, 0);
        check("R11", "out-of-box reads", oob_cnt, 0);
    endtask

    initial begin
        clear_mon();
        t_reset();
        t_tall_box();
        t_identity();
        t_single_clamp();
        t_single_zero();
        t_small_both();
        t_large();
        t_busy_start();
        t_zero_dim();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

endmodule